// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Unit

This block is a bank of up to 32 general-purpose pins, reached through a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Software uses it to choose which pins drive, to raise and lower output levels one bit at a time, and to read the pin levels through a synchronizer.

Every pin also has its own event detector. A type bit picks level or edge sensing, and a polarity bit picks high/rising or low/falling. An enable bit lets a pin record events into a pending register. A separate mask bit decides whether a recorded event reaches the single registered interrupt line that goes to a parent controller. The hardware detects only one edge direction per pin. To catch both edges, software flips the polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, pin_oe, pin_out and irq are 0, and the output-enable (0x00), enable (0x14), type (0x18), polarity (0x1C), pending (0x20) and mask (0x24) registers all read 0.
- R2: The output-enable register at offset 0x00 stores written data and reads it back. pin_oe follows it from the clock edge that performs the write.
- R3: A write to offset 0x0C drives the output bits given as 1 high, and a write to 0x10 drives them low. Bits given as 0 leave outputs unchanged, and a read at either offset returns the current output levels.
- R4: Offset 0x04 returns the pin inputs after a two-register synchronizer, so a change is visible after two clock edges and not after one. Writes to 0x04 have no effect.
- R5: With its type bit (0x18) at 0, a pin is edge-sensitive. A polarity bit (0x1C) of 1 records only rising edges, and 0 records only falling edges. The opposite edge sets nothing.
- R6: With its type bit at 1, a pin's pending bit is 1 exactly while the synchronized level equals the polarity bit and the pin is enabled. Writing 1 to its pending bit has no lasting effect.
- R7: An edge pending bit stays set until 1 is written to that bit at offset 0x20. Writing 1 to other bits or writing 0 leaves it set.
- R8: A pin whose enable bit (0x14) is 0 records no new pending event, and irq stays low for it.
- R9: irq is the registered OR over all pins of pending AND enable AND mask (0x24). A masked pin still shows its pending bit but does not raise irq.
- R10: An input change that causes an edge event shows in the pending register three clock edges after it reaches the pin, and on irq one edge later.
- R11: Addresses outside the map read as 0. Writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables, 1 = drive |
| irq | output | 1 | Registered interrupt to the parent controller |

## Verification
Most faults in the pin detectors show at the ports within four clock edges of a pin change. A pending bit that is lost or never set appears at offset 0x20 three edges after the input change, and a wrong gating term appears on irq one edge later. A corrupted previous-sample flop or a wrong synchronizer depth shifts the edge or drops it. The bench catches this because it samples each pending read at the exact cycle boundary. Faults in the output and configuration registers appear on pin_oe, pin_out or the readback on the first cycle after the write. Faults in pending bits that should hold are checked by waiting and then issuing decoy clears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned OFS_OE   = 32'h00;
   localparam int unsigned OFS_IN   = 32'h04;
   localparam int unsigned OFS_SET  = 32'h0C;
   localparam int unsigned OFS_CLR  = 32'h10;
   localparam int unsigned OFS_EN   = 32'h14;
   localparam int unsigned OFS_TYP  = 32'h18;
   localparam int unsigned OFS_POL  = 32'h1C;
   localparam int unsigned OFS_PEND = 32'h20;
   localparam int unsigned OFS_MASK = 32'h24;

   typedef enum logic [3:0] {
      SEL_OE, SEL_IN, SEL_SET, SEL_CLR, SEL_EN,
      SEL_TYP, SEL_POL, SEL_PEND, SEL_MASK, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [31:0] a);
      case (a)
         OFS_OE:   return SEL_OE;
         OFS_IN:   return SEL_IN;
         OFS_SET:  return SEL_SET;
         OFS_CLR:  return SEL_CLR;
         OFS_EN:   return SEL_EN;
         OFS_TYP:  return SEL_TYP;
         OFS_POL:  return SEL_POL;
         OFS_PEND: return SEL_PEND;
         OFS_MASK: return SEL_MASK;
         default:  return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic is_level,
   input  logic act_high,
   input  logic enable,
   input  logic clear,
   output logic pending
);
   logic prev_q;
   logic pend_q;
   logic level_hit;
   logic edge_hit;
   logic pend_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      level_hit = (lvl == act_high);
      edge_hit  = act_high ? (lvl & ~prev_q) : (~lvl & prev_q);
      if (is_level) pend_d = level_hit & enable;
      else          pend_d = (pend_q & ~clear) | (edge_hit & enable);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign pending = pend_q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   input  logic [W-1:0] en,
   input  logic [W-1:0] mask,
   output logic         irq
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend & en & mask);
   end

   assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   import gpio_irq_pkg::*;

   localparam int N = NUM_PINS;

   initial begin
      assert (NUM_PINS >= 1 && NUM_PINS <= 32) else $error("NUM_PINS out of range");
      assert (ADDR_W >= 6 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
   end

   logic [N-1:0] oe_q, out_q, en_q, typ_q, pol_q, mask_q;
   logic [N-1:0] pend_q, sync_lvl, clr_vec, wbits;
   reg_sel_e     sel;
   logic         wr_oe, wr_set, wr_clr, wr_en, wr_typ, wr_pol, wr_mask;

   assign sel     = decode_sel(32'(bus_addr));
   assign wbits   = bus_wdata[N-1:0];
   assign wr_oe   = bus_wr && (sel == SEL_OE);
   assign wr_set  = bus_wr && (sel == SEL_SET);
   assign wr_clr  = bus_wr && (sel == SEL_CLR);
   assign wr_en   = bus_wr && (sel == SEL_EN);
   assign wr_typ  = bus_wr && (sel == SEL_TYP);
   assign wr_pol  = bus_wr && (sel == SEL_POL);
   assign wr_mask = bus_wr && (sel == SEL_MASK);
   assign clr_vec = (bus_wr && (sel == SEL_PEND)) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= '0;
         out_q  <= '0;
         en_q   <= '0;
         typ_q  <= '0;
         pol_q  <= '0;
         mask_q <= '0;
      end else begin
         if (wr_oe)   oe_q   <= wbits;
         if (wr_set)  out_q  <= out_q | wbits;
         if (wr_clr)  out_q  <= out_q & ~wbits;
         if (wr_en)   en_q   <= wbits;
         if (wr_typ)  typ_q  <= wbits;
         if (wr_pol)  pol_q  <= wbits;
         if (wr_mask) mask_q <= wbits;
      end
   end

   gpio_in_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_lvl)
   );

   for (genvar i = 0; i < N; i++) begin : g_pin
      gpio_pin_irq u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (sync_lvl[i]),
         .is_level (typ_q[i]),
         .act_high (pol_q[i]),
         .enable   (en_q[i]),
         .clear    (clr_vec[i]),
         .pending  (pend_q[i])
      );
   end

   gpio_irq_merge #(.W(N)) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_q),
      .en    (en_q),
      .mask  (mask_q),
      .irq   (irq)
   );

   always_comb begin
      case (sel)
         SEL_OE:           bus_rdata = 32'(oe_q);
         SEL_IN:           bus_rdata = 32'(sync_lvl);
         SEL_SET, SEL_CLR: bus_rdata = 32'(out_q);
         SEL_EN:           bus_rdata = 32'(en_q);
         SEL_TYP:          bus_rdata = 32'(typ_q);
         SEL_POL:          bus_rdata = 32'(pol_q);
         SEL_PEND:         bus_rdata = 32'(pend_q);
         SEL_MASK:         bus_rdata = 32'(mask_q);
         default:          bus_rdata = 32'h0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = oe_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] en,
   input logic [NUM_PINS-1:0] mask,
   input logic [NUM_PINS-1:0] typ
);
   import gpio_irq_pkg::*;

   logic [NUM_PINS-1:0] wv, w1c;
   logic                hit_oe, hit_set, hit_clr;

   assign wv      = bus_wdata[NUM_PINS-1:0];
   assign hit_oe  = bus_wr && (32'(bus_addr) == OFS_OE);
   assign hit_set = bus_wr && (32'(bus_addr) == OFS_SET);
   assign hit_clr = bus_wr && (32'(bus_addr) == OFS_CLR);
   assign w1c     = (bus_wr && (32'(bus_addr) == OFS_PEND)) ? wv : '0;

   assert_oe_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_oe |=> $stable(pin_oe));

   assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((pin_out & $past(wv)) == $past(wv)));

   assert_clr_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> ((pin_out & $past(wv)) == '0));

   assert_out_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_set || hit_clr) |=> $stable(pin_out));

   assert_edge_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend & $past(pend & ~typ & ~w1c)) == '0));

   assert_no_event_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

   assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !irq);

   assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .pend      (pend_q),
   .en        (en_q),
   .mask      (mask_q),
   .typ       (typ_q)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_now(a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [31:0] typ, input logic [31:0] pol,
                      input logic [31:0] en, input logic [31:0] msk);
      wr(8'h14, 32'h0);
      wr(8'h24, 32'h0);
      pin_in = '0;
      idle(4);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h18, typ);
      wr(8'h1C, pol);
      wr(8'h14, en);
      wr(8'h24, msk);
      idle(2);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 pin_oe", 32'(pin_oe), 32'h0);
      check("R1 pin_out", 32'(pin_out), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      foreach (v[i]) begin end
      rd(8'h00, v); check("R1 oe reg", v, 32'h0);
      rd(8'h14, v); check("R1 en reg", v, 32'h0);
      rd(8'h18, v); check("R1 typ reg", v, 32'h0);
      rd(8'h1C, v); check("R1 pol reg", v, 32'h0);
      rd(8'h20, v); check("R1 pend reg", v, 32'h0);
      rd(8'h24, v); check("R1 mask reg", v, 32'h0);
   endtask

   task automatic t_oe;
      logic [31:0] v;
      wr(8'h00, 32'hA5A5_0F0F);
      check("R2 pin_oe", 32'(pin_oe), 32'hA5A5_0F0F);
      rd(8'h00, v); check("R2 readback", v, 32'hA5A5_0F0F);
   endtask

   task automatic t_setclr;
      logic [31:0] v;
      wr(8'h0C, 32'h0000_00F0);
      check("R3 set", 32'(pin_out), 32'h0000_00F0);
      wr(8'h0C, 32'h0000_0003);
      check("R3 set keeps zeros", 32'(pin_out), 32'h0000_00F3);
      wr(8'h10, 32'h0000_0030);
      check("R3 clear", 32'(pin_out), 32'h0000_00C3);
      rd(8'h0C, v); check("R3 read at set", v, 32'h0000_00C3);
      rd(8'h10, v); check("R3 read at clear", v, 32'h0000_00C3);
   endtask

   task automatic t_input;
      logic [31:0] v;
      @(negedge clk);
      pin_in = 32'h1234_5678;
      @(negedge clk);
      rd_now(8'h04, v); check("R4 not after one edge", v, 32'h0);
      @(negedge clk);
      rd_now(8'h04, v); check("R4 after two edges", v, 32'h1234_5678);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, v); check("R4 write ignored", v, 32'h1234_5678);
   endtask

   task automatic t_edge_rise;
      logic [31:0] v;
      cfg(32'h0, 32'h1, 32'h1, 32'h1);
      rd(8'h20, v); check("R5 quiet before edge", v, 32'h0);
      @(negedge clk);
      pin_in[0] = 1'b1;
      idle(2);
      rd_now(8'h20, v); check("R10 not after two edges", v, 32'h0);
      @(negedge clk);
      rd_now(8'h20, v); check("R10 pending after three edges", v, 32'h1);
      check("R10 irq not yet", 32'(irq), 32'h0);
      @(negedge clk);
      check("R10 irq one edge later", 32'(irq), 32'h1);
      pin_in[0] = 1'b0;
      idle(5);
      rd(8'h20, v); check("R7 sticky after fall", v, 32'h1);
      wr(8'h20, 32'h0000_0002);
      rd(8'h20, v); check("R7 other-bit clear ignored", v, 32'h1);
      wr(8'h20, 32'h0);
      rd(8'h20, v); check("R7 zero clear ignored", v, 32'h1);
      wr(8'h20, 32'h0000_0001);
      rd_now(8'h20, v); check("R7 cleared", v, 32'h0);
      @(negedge clk);
      check("R9 irq drops", 32'(irq), 32'h0);
   endtask

   task automatic t_edge_fall;
      logic [31:0] v;
      cfg(32'h0, 32'h0, 32'h2, 32'h2);
      @(negedge clk);
      pin_in[1] = 1'b1;
      idle(5);
      rd(8'h20, v); check("R5 rise ignored on falling pin", v, 32'h0);
      pin_in[1] = 1'b0;
      idle(5);
      rd(8'h20, v); check("R5 fall captured", v, 32'h2);
      check("R9 irq for falling pin", 32'(irq), 32'h1);
   endtask

   task automatic t_level;
      logic [31:0] v;
      cfg(32'h4, 32'h4, 32'h4, 32'h4);
      rd(8'h20, v); check("R6 low pin not pending", v, 32'h0);
      pin_in[2] = 1'b1;
      idle(4);
      rd(8'h20, v); check("R6 high level pending", v, 32'h4);
      wr(8'h20, 32'h4);
      rd(8'h20, v); check("R6 clear has no lasting effect", v, 32'h4);
      pin_in[2] = 1'b0;
      idle(4);
      rd(8'h20, v); check("R6 follows level away", v, 32'h0);
      check("R6 irq drops", 32'(irq), 32'h0);
      wr(8'h1C, 32'h0);
      idle(2);
      rd(8'h20, v); check("R6 low level pending", v, 32'h4);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      cfg(32'h0, 32'h8, 32'h0, 32'h8);
      @(negedge clk);
      pin_in[3] = 1'b1;
      idle(5);
      rd(8'h20, v); check("R8 disabled pin records nothing", v, 32'h0);
      check("R8 irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      cfg(32'h0, 32'h10, 32'h10, 32'h0);
      @(negedge clk);
      pin_in[4] = 1'b1;
      idle(5);
      rd(8'h20, v); check("R9 masked pending visible", v, 32'h10);
      check("R9 masked irq low", 32'(irq), 32'h0);
      wr(8'h24, 32'h10);
      @(negedge clk);
      check("R9 unmask raises irq", 32'(irq), 32'h1);
      wr(8'h14, 32'h0);
      @(negedge clk);
      check("R9 disable lowers irq", 32'(irq), 32'h0);
      rd(8'h20, v); check("R9 pending kept while disabled", v, 32'h10);
   endtask

   task automatic t_unmapped;
      logic [31:0] v, oe0, out0;
      oe0 = 32'(pin_oe); out0 = 32'(pin_out);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h08, v); check("R11 read 0x08", v, 32'h0);
      rd(8'h28, v); check("R11 read 0x28", v, 32'h0);
      check("R11 oe unchanged", 32'(pin_oe), oe0);
      check("R11 out unchanged", 32'(pin_out), out0);
      rd(8'h14, v); check("R11 en unchanged", v, 32'h0);
   endtask

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_oe();
      t_setclr();
      t_input();
      t_edge_rise();
      t_edge_fall();
      t_level();
      t_enable();
      t_mask();
      t_unmapped();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog R1-timeout actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule